// File: doc/BRIEF.md
# Slave Stereo Audio Serial Port

This block connects a 16-bit stereo converter pair to a serial audio link whose bit clock and channel clock come from outside. The outgoing converter samples (ADC words) leave on the serial output and the incoming samples (DAC words) arrive on the serial input. Both use two's complement and travel most significant bit first. A word on the output starts in the first bit slot of its half-frame. A word on the input ends in the last bit slot of its half-frame. Because of this, one frame mixes a start-aligned stream with an end-aligned stream.

Every external line passes through a synchronizer and is sampled on a faster system clock. The block finds the bit-clock edges and the channel-clock changes there. On the parallel side, a load strobe takes a left/right pair of outgoing words. When a full left/right pair has been received, the block presents it with a one-cycle valid pulse. A mode input selects 16 or 32 bit slots per channel, which is a bit clock of 32 or 64 times the frame rate.

Top module: `audio_serial_port`

## Requirements
- R1: While reset is high and in the first cycle after it, `sdto_out` is 0, `dac_valid` is 0 and both received words are 0.
- R2: After each channel-clock change, `sdto_out` carries the held word for that channel MSB first. Bit 15 is in slot 0 and bit 0 is in slot 15. The output changes only after a detected bit-clock falling edge or channel-clock change.
- R3: With `mode_64` = 1, `sdto_out` is 0 in slots 16 to 31 of each half-frame.
- R4: `lrck_in` = 1 marks the left channel and `lrck_in` = 0 marks the right channel, for both directions. The left half comes first in a frame.
- R5: With `mode_64` = 0, the 16 bits sampled on the bit-clock rising edges of a half-frame form the received word, MSB first.
- R6: With `mode_64` = 1, only slots 16 to 31 form the received word. Input bits in slots 0 to 15 have no effect on it.
- R7: After the last right-channel bit is captured, `dac_left` and `dac_right` take the new pair and `dac_valid` is high for exactly one system cycle. The received words hold their values at all other times.
- R8: `adc_load` captures `adc_left` and `adc_right` into hold registers. Each channel takes its word at the start of its own half-frame, so a load during the left half does not change the left word being sent but does supply the next right word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_64 | input | 1 | 1: 32 slots per channel; 0: 16 slots per channel |
| bclk_in | input | 1 | External bit clock |
| lrck_in | input | 1 | External channel clock, high for left |
| sdti_in | input | 1 | Serial input carrying DAC samples |
| sdto_out | output | 1 | Serial output carrying ADC samples |
| adc_left | input | 16 | Left word to send |
| adc_right | input | 16 | Right word to send |
| adc_load | input | 1 | Strobe that captures both outgoing words |
| dac_left | output | 16 | Last received left word |
| dac_right | output | 16 | Last received right word |
| dac_valid | output | 1 | One-cycle pulse when a received pair is presented |

## Verification
A wrong slot count or a transmit shifter that does not clear shows up within one half-frame. In the first case the received word comes out shifted by whole bits. In the second case nonzero bits appear in the unused 64-slot positions. A channel-level mix-up swaps the left and right words at the next valid pulse. A stale hold register shows up as a wrong outgoing word in the half-frame that follows a mid-frame load. The directed frames cover both modes, junk bits in the ignored input slots, and a load during transmission, so each of these faults appears at the ports within one frame.

// File: rtl/asp_pkg.sv
package asp_pkg;
  parameter int SAMPLE_W = 16;
  parameter int SYNC_STAGES = 2;
  localparam int SLOTS_MAX = 2 * SAMPLE_W;
  localparam int SLOT_W = $clog2(SLOTS_MAX);
endpackage

// File: rtl/asp_sync.sv
module asp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_prev
);
  logic [STAGES:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i <= STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q      = chain[STAGES-1];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/asp_tx.sv
module asp_tx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lr_change,
  input  logic         lr_level,
  input  logic         bclk_fall,
  input  logic [W-1:0] word_l,
  input  logic [W-1:0] word_r,
  output logic         sdto
);
  logic [W-1:0] shreg;
  logic [W-1:0] start_word;

  always_comb start_word = lr_level ? word_l : word_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      sdto  <= 1'b0;
    end else if (lr_change) begin
      shreg <= start_word;
      sdto  <= start_word[W-1];
    end else if (bclk_fall) begin
      shreg <= {shreg[W-2:0], 1'b0};
      sdto  <= shreg[W-2];
    end
  end
endmodule

// File: rtl/asp_rx.sv
module asp_rx #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_64,
  input  logic         lr_change,
  input  logic         lr_level,
  input  logic         bclk_rise,
  input  logic         sdti_bit,
  output logic [W-1:0] out_l,
  output logic [W-1:0] out_r,
  output logic         out_valid
);
  localparam int SW = $clog2(2 * W);

  logic [SW-1:0] slot;
  logic [SW-1:0] last_slot;
  logic [W-1:0]  shreg;
  logic [W-1:0]  left_stage;
  logic [W-1:0]  word_next;

  always_comb begin
    last_slot = mode_64 ? SW'(2 * W - 1) : SW'(W - 1);
    word_next = {shreg[W-2:0], sdti_bit};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot       <= '0;
      shreg      <= '0;
      left_stage <= '0;
      out_l      <= '0;
      out_r      <= '0;
      out_valid  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (lr_change) begin
        slot <= '0;
      end else if (bclk_rise) begin
        shreg <= word_next;
        slot  <= slot + 1'b1;
        if (slot == last_slot) begin
          if (lr_level) begin
            left_stage <= word_next;
          end else begin
            out_l     <= left_stage;
            out_r     <= word_next;
            out_valid <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
  parameter int SAMPLE_W    = asp_pkg::SAMPLE_W,
  parameter int SYNC_STAGES = asp_pkg::SYNC_STAGES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_64,
  input  logic                bclk_in,
  input  logic                lrck_in,
  input  logic                sdti_in,
  output logic                sdto_out,
  input  logic [SAMPLE_W-1:0] adc_left,
  input  logic [SAMPLE_W-1:0] adc_right,
  input  logic                adc_load,
  output logic [SAMPLE_W-1:0] dac_left,
  output logic [SAMPLE_W-1:0] dac_right,
  output logic                dac_valid
);
  localparam int NLINES = 3;

  logic [NLINES-1:0] sync_q;
  logic [NLINES-1:0] sync_p;
  logic bclk_rise, bclk_fall, lr_change, lr_level, sdti_bit;
  logic [SAMPLE_W-1:0] hold_l, hold_r;

  asp_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({sdti_in, lrck_in, bclk_in}),
    .q(sync_q), .q_prev(sync_p)
  );

  always_comb begin
    bclk_rise = sync_q[0] & ~sync_p[0];
    bclk_fall = ~sync_q[0] & sync_p[0];
    lr_change = sync_q[1] ^ sync_p[1];
    lr_level  = sync_q[1];
    sdti_bit  = sync_q[2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_l <= '0;
      hold_r <= '0;
    end else if (adc_load) begin
      hold_l <= adc_left;
      hold_r <= adc_right;
    end
  end

  asp_tx #(.W(SAMPLE_W)) u_tx (
    .clk(clk), .rst(rst), .lr_change(lr_change), .lr_level(lr_level),
    .bclk_fall(bclk_fall), .word_l(hold_l), .word_r(hold_r), .sdto(sdto_out)
  );

  asp_rx #(.W(SAMPLE_W)) u_rx (
    .clk(clk), .rst(rst), .mode_64(mode_64), .lr_change(lr_change),
    .lr_level(lr_level), .bclk_rise(bclk_rise), .sdti_bit(sdti_bit),
    .out_l(dac_left), .out_r(dac_right), .out_valid(dac_valid)
  );
endmodule

// File: rtl/asp_checker.sv
module asp_checker #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                mode_64,
  input logic                lr_change,
  input logic                lr_level,
  input logic                bclk_fall,
  input logic                sdto_out,
  input logic                dac_valid,
  input logic [SAMPLE_W-1:0] dac_left,
  input logic [SAMPLE_W-1:0] dac_right
);
  int falls_seen;

  always_ff @(posedge clk) begin
    if (rst || lr_change) falls_seen <= 0;
    else if (bclk_fall && falls_seen < 2 * SAMPLE_W) falls_seen <= falls_seen + 1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!sdto_out && !dac_valid && dac_left == '0 && dac_right == '0));

  assert_sdto_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!lr_change && !bclk_fall) |=> $stable(sdto_out));

  assert_tail_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_64 && bclk_fall && !lr_change && falls_seen >= SAMPLE_W - 1) |=> !sdto_out);

  assert_valid_right_R4: assert property (@(posedge clk) disable iff (rst)
    dac_valid |-> !lr_level);

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    dac_valid |=> !dac_valid);

  assert_dac_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !dac_valid |-> ($stable(dac_left) && $stable(dac_right)));
endmodule

bind audio_serial_port asp_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst(rst), .mode_64(mode_64), .lr_change(lr_change),
  .lr_level(lr_level), .bclk_fall(bclk_fall), .sdto_out(sdto_out),
  .dac_valid(dac_valid), .dac_left(dac_left), .dac_right(dac_right)
);

// File: tb/audio_serial_port_tb.sv
`timescale 1ns/1ps
module audio_serial_port_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_64 = 1'b0;
  logic bclk_in = 1'b1;
  logic lrck_in = 1'b0;
  logic sdti_in = 1'b0;
  logic sdto_out;
  logic [15:0] adc_left = '0, adc_right = '0;
  logic adc_load = 1'b0;
  logic [15:0] dac_left, dac_right;
  logic dac_valid;

  int errors = 0;
  int checks = 0;
  int vcnt = 0;
  int wide_err = 0;
  logic vprev = 1'b0;
  logic [15:0] cap_l = '0, cap_r = '0;

  always #5 clk = ~clk;

  audio_serial_port u_dut (
    .clk(clk), .rst(rst), .mode_64(mode_64), .bclk_in(bclk_in),
    .lrck_in(lrck_in), .sdti_in(sdti_in), .sdto_out(sdto_out),
    .adc_left(adc_left), .adc_right(adc_right), .adc_load(adc_load),
    .dac_left(dac_left), .dac_right(dac_right), .dac_valid(dac_valid)
  );

  always @(negedge clk) begin
    if (dac_valid) begin
      vcnt++;
      cap_l = dac_left;
      cap_r = dac_right;
      if (vprev) wide_err++;
    end
    vprev = dac_valid;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_words(input logic [15:0] l, input logic [15:0] r);
    adc_left = l; adc_right = r; adc_load = 1'b1;
    #10 adc_load = 1'b0;
    #10;
  endtask

  task automatic do_half(input logic lvl, input int nslots, input logic [15:0] rxw,
                         input bit ld, input logic [15:0] ldl, input logic [15:0] ldr,
                         output logic [31:0] txbits);
    txbits = '0;
    for (int k = 0; k < nslots; k++) begin
      int idx;
      bclk_in = 1'b0;
      if (k == 0) lrck_in = lvl;
      idx = k - (nslots - 16);
      sdti_in = (idx >= 0) ? rxw[15 - idx] : ((k % 3) != 1);
      #70 txbits[31 - k] = sdto_out;
      #10 bclk_in = 1'b1;
      if (ld && k == 8) begin
        #40 adc_left = ldl; adc_right = ldr; adc_load = 1'b1;
        #10 adc_load = 1'b0;
        #30;
      end else begin
        #80;
      end
    end
  endtask

  task automatic do_frame(input logic m64, input logic [15:0] rxl, input logic [15:0] rxr,
                          input bit ld, input logic [15:0] ldl, input logic [15:0] ldr,
                          output logic [31:0] txl, output logic [31:0] txr);
    int n;
    mode_64 = m64;
    n = m64 ? 32 : 16;
    #40;
    do_half(1'b1, n, rxl, ld, ldl, ldr, txl);
    do_half(1'b0, n, rxr, 1'b0, 16'h0, 16'h0, txr);
    #40;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 sdto in reset", {31'b0, sdto_out}, 32'd0);
    chk("R1 valid in reset", {31'b0, dac_valid}, 32'd0);
    chk("R1 dac words in reset", {dac_left, dac_right}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {15'b0, sdto_out, dac_valid, dac_left}, 32'd0);
  endtask

  task automatic t_frame32;
    logic [31:0] tl, tr;
    int v0;
    load_words(16'hA5C3, 16'h1234);
    v0 = vcnt;
    do_frame(1'b0, 16'h8001, 16'h7FFE, 1'b0, 16'h0, 16'h0, tl, tr);
    chk("R2 left tx 32fs", {16'h0, tl[31:16]}, 32'h0000A5C3);
    chk("R4 right tx 32fs", {16'h0, tr[31:16]}, 32'h00001234);
    chk("R5 left rx 32fs", {16'h0, cap_l}, 32'h00008001);
    chk("R5 right rx 32fs", {16'h0, cap_r}, 32'h00007FFE);
    chk("R7 one valid per frame", vcnt - v0, 32'd1);
  endtask

  task automatic t_frame64;
    logic [31:0] tl, tr;
    int v0;
    load_words(16'h3C5A, 16'hF00F);
    v0 = vcnt;
    do_frame(1'b1, 16'h1357, 16'hECA8, 1'b0, 16'h0, 16'h0, tl, tr);
    chk("R2 left tx 64fs", {16'h0, tl[31:16]}, 32'h00003C5A);
    chk("R4 right tx 64fs", {16'h0, tr[31:16]}, 32'h0000F00F);
    chk("R3 left tail zero", {16'h0, tl[15:0]}, 32'h0);
    chk("R3 right tail zero", {16'h0, tr[15:0]}, 32'h0);
    chk("R6 left rx 64fs", {16'h0, cap_l}, 32'h00001357);
    chk("R6 right rx 64fs", {16'h0, cap_r}, 32'h0000ECA8);
    chk("R7 one valid 64fs", vcnt - v0, 32'd1);
  endtask

  task automatic t_midload;
    logic [31:0] tl, tr;
    load_words(16'h0F0F, 16'h1111);
    do_frame(1'b0, 16'h0001, 16'h8000, 1'b1, 16'h2222, 16'h4444, tl, tr);
    chk("R8 left unaffected by mid load", {16'h0, tl[31:16]}, 32'h00000F0F);
    chk("R8 right takes new word", {16'h0, tr[31:16]}, 32'h00004444);
    chk("R4 rx after mid load", {cap_l, cap_r}, 32'h00018000);
    do_frame(1'b0, 16'hFFFF, 16'h0000, 1'b0, 16'h0, 16'h0, tl, tr);
    chk("R8 next left from new load", {16'h0, tl[31:16]}, 32'h00002222);
    chk("R5 extremes rx", {cap_l, cap_r}, 32'hFFFF0000);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_frame32();
    t_frame64();
    t_midload();
    chk("R7 valid width one cycle", wide_err, 32'd0);
    chk("R7 total valid pulses", vcnt, 32'd4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule